// File: doc/BRIEF.md
# Interrupt Entry Stacking Sequencer

This block performs the entry sequence once an interrupt has been accepted. A pulse on `start_i` captures the interrupted instruction's address, the status word, the supervisor stack pointer, the vector table base, and the accepted request's level and number. The block then pushes the status word and the return address onto the supervisor stack. It writes a new status word with the level mask set to the request's level and the stack-select flag cleared. It reads the handler address from the vector table and loads it into the program counter.

The return address depends on the class of the interrupted instruction. Each memory access gets its own FSM state, so a full entry takes five busy cycles. The last of these is a one-cycle completion pulse, which also asks the pipeline to check again for pending exceptions before the handler's first instruction runs. The memory port is word-wide and byte-addressed, and read data returns in the cycle after the request.

Top module: `irq_entry_seq`

## Requirements
- R1: While `rst_ni` is low, and in every idle cycle, `busy_o`, `mem_req_o`, `mem_we_o`, `ssp_we_o`, `ps_we_o`, `pc_we_o`, `done_o` and `recheck_o` are all 0.
- R2: In the cycle after `start_i` is sampled high while idle, the block issues a memory write of the captured status word to captured SSP minus 4. In the same cycle it drives `ssp_we_o` with `ssp_o` equal to that address.
- R3: In the following cycle, the block writes the return address to captured SSP minus 8, with `ssp_we_o` and `ssp_o` equal to SSP minus 8.
- R4: The return address is the instruction address plus 6 for class code 2 (32-bit immediate load). It is plus 4 for class code 1 (20-bit immediate load and coprocessor instructions). It is plus 2 for class codes 0 and 3.
- R5: In the third cycle, `ps_we_o` is high. `ps_o` equals the captured status word with bits [20:16] replaced by the request level and bit 5 (stack select) cleared. All other bits are unchanged. The same cycle issues a memory read.
- R6: The read address is the table base plus 0x3FC minus 4 times the interrupt number. In the fourth cycle, `pc_we_o` is high and `pc_o` equals `mem_rdata_i`.
- R7: In the fifth cycle, `done_o` and `recheck_o` are high for exactly one cycle, and `busy_o` is still high. The block is idle in the cycle after that.
- R8: `start_i` has no effect while `busy_o` is high. Once the current sequence completes, the block returns to idle and does not start a new sequence.
- R9: Changes on the captured inputs after the start cycle do not alter any value the sequence writes.
- R10: Interrupt number 0 reads table base plus 0x3FC. Interrupt number 255 reads the table base itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin entry sequence (sampled when idle) |
| irq_level_i | input | LVL_W | Level of accepted request |
| irq_num_i | input | NUM_W | Number of accepted request |
| insn_class_i | input | 2 | Class of interrupted instruction |
| pc_i | input | XLEN | Address of interrupted instruction |
| ps_i | input | XLEN | Current status word |
| ssp_i | input | XLEN | Current supervisor stack pointer |
| tbr_i | input | XLEN | Vector table base |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | XLEN | Byte address |
| mem_wdata_o | output | XLEN | Write data |
| mem_rdata_i | input | XLEN | Read data, one cycle after request |
| ssp_we_o | output | 1 | Stack pointer update strobe |
| ssp_o | output | XLEN | New stack pointer |
| ps_we_o | output | 1 | Status word update strobe |
| ps_o | output | XLEN | New status word |
| pc_we_o | output | 1 | Program counter load strobe |
| pc_o | output | XLEN | Handler address |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| recheck_o | output | 1 | Request fresh exception check |

## Verification
The sequence is tried with all four instruction-class codes, so that a wrong or swapped offset shows up in the second stack write. Interrupt numbers 0, 255 and a middle value, together with several table bases, distinguish a wrong vector scaling or sign from a correct one. Level values of 0, 31 and a mixed pattern, written into status words of all ones and of alternating bits, expose a misplaced mask field or an untouched stack-select bit. In one run, the inputs are scrambled and `start_i` is held high after the start cycle, which separates correct capture and busy-blocking from a block that re-samples its inputs.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_PS,
    ST_PUSH_RA,
    ST_VEC_RD,
    ST_LOAD_PC,
    ST_FIN
  } seq_state_e;

  typedef enum logic [1:0] {
    CLS_SHORT = 2'd0,
    CLS_MID   = 2'd1,
    CLS_LONG  = 2'd2,
    CLS_RSVD  = 2'd3
  } insn_cls_e;
endpackage

// File: rtl/irq_ret_addr.sv
module irq_ret_addr
  import irq_entry_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] pc_i,
  input  insn_cls_e       cls_i,
  output logic [XLEN-1:0] ra_o
);
  logic [XLEN-1:0] step;

  always_comb begin
    unique case (cls_i)
      CLS_LONG: step = XLEN'(6);
      CLS_MID:  step = XLEN'(4);
      default:  step = XLEN'(2);
    endcase
  end

  assign ra_o = pc_i + step;
endmodule

// File: rtl/irq_vec_addr.sv
module irq_vec_addr #(
  parameter int XLEN  = 32,
  parameter int NUM_W = 8
) (
  input  logic [XLEN-1:0]  tbr_i,
  input  logic [NUM_W-1:0] num_i,
  output logic [XLEN-1:0]  addr_o
);
  localparam int OFS_W = NUM_W + 2;

  // top slot minus 4*num == {~num, 2'b00}
  logic [OFS_W-1:0] ofs;
  assign ofs    = {~num_i, 2'b00};
  assign addr_o = tbr_i + XLEN'(ofs);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int NUM_W   = 8,
  parameter int LVL_W   = 5,
  parameter int ILM_LSB = 16,
  parameter int S_BIT   = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LVL_W-1:0] irq_level_i,
  input  logic [NUM_W-1:0] irq_num_i,
  input  logic [1:0]       insn_class_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  ps_i,
  input  logic [XLEN-1:0]  ssp_i,
  input  logic [XLEN-1:0]  tbr_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [XLEN-1:0]  mem_addr_o,
  output logic [XLEN-1:0]  mem_wdata_o,
  input  logic [XLEN-1:0]  mem_rdata_i,
  output logic             ssp_we_o,
  output logic [XLEN-1:0]  ssp_o,
  output logic             ps_we_o,
  output logic [XLEN-1:0]  ps_o,
  output logic             pc_we_o,
  output logic [XLEN-1:0]  pc_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             recheck_o
);
  localparam logic [XLEN-1:0] WORD = XLEN'(4);

  seq_state_e       state_q, state_d;
  logic [XLEN-1:0]  pc_q, ps_q, ssp_q, tbr_q;
  logic [LVL_W-1:0] lvl_q;
  logic [NUM_W-1:0] num_q;
  insn_cls_e        cls_q;
  logic [XLEN-1:0]  ra, vec_addr, ps_new, sp_m1, sp_m2;
  logic             take;

  assign take = (state_q == ST_IDLE) && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
      ps_q    <= '0;
      ssp_q   <= '0;
      tbr_q   <= '0;
      lvl_q   <= '0;
      num_q   <= '0;
      cls_q   <= CLS_SHORT;
    end else begin
      state_q <= state_d;
      if (take) begin
        pc_q  <= pc_i;
        ps_q  <= ps_i;
        ssp_q <= ssp_i;
        tbr_q <= tbr_i;
        lvl_q <= irq_level_i;
        num_q <= irq_num_i;
        cls_q <= insn_cls_e'(insn_class_i);
      end
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_PUSH_PS;
      ST_PUSH_PS: state_d = ST_PUSH_RA;
      ST_PUSH_RA: state_d = ST_VEC_RD;
      ST_VEC_RD:  state_d = ST_LOAD_PC;
      ST_LOAD_PC: state_d = ST_FIN;
      ST_FIN:     state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  irq_ret_addr #(.XLEN(XLEN)) u_ret (
    .pc_i  (pc_q),
    .cls_i (cls_q),
    .ra_o  (ra)
  );

  irq_vec_addr #(.XLEN(XLEN), .NUM_W(NUM_W)) u_vec (
    .tbr_i  (tbr_q),
    .num_i  (num_q),
    .addr_o (vec_addr)
  );

  assign sp_m1 = ssp_q - WORD;
  assign sp_m2 = ssp_q - (WORD + WORD);

  always_comb begin
    ps_new                       = ps_q;
    ps_new[ILM_LSB +: LVL_W]     = lvl_q;
    ps_new[S_BIT]                = 1'b0;
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    ssp_we_o    = 1'b0;
    ssp_o       = '0;
    ps_we_o     = 1'b0;
    ps_o        = '0;
    pc_we_o     = 1'b0;
    pc_o        = '0;
    done_o      = 1'b0;
    unique case (state_q)
      ST_PUSH_PS: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = sp_m1;
        mem_wdata_o = ps_q;
        ssp_we_o    = 1'b1;
        ssp_o       = sp_m1;
      end
      ST_PUSH_RA: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = sp_m2;
        mem_wdata_o = ra;
        ssp_we_o    = 1'b1;
        ssp_o       = sp_m2;
      end
      ST_VEC_RD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = vec_addr;
        ps_we_o    = 1'b1;
        ps_o       = ps_new;
      end
      ST_LOAD_PC: begin
        pc_we_o = 1'b1;
        pc_o    = mem_rdata_i;
      end
      ST_FIN:  done_o = 1'b1;
      default: ;
    endcase
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign recheck_o = done_o;

  AST_START_PUSH_SSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (ssp_we_o && ssp_o == $past(ssp_i) - WORD)); // R2
  AST_STACK_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && $past(mem_req_o && mem_we_o))
      |-> (mem_addr_o == $past(mem_addr_o) - WORD)); // R3
  AST_MASK_AFTER_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ps_we_o |-> $past(mem_req_o && mem_we_o)); // R5
  AST_PC_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_o |-> $past(mem_req_o && !mem_we_o)); // R6
  AST_DONE_AFTER_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(pc_we_o)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o); // R7
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o); // R8
endmodule

// File: tb/irq_entry_seq_test.sv
`timescale 1ns/1ps
module irq_entry_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [4:0]  lvl_i;
  logic [7:0]  num_i;
  logic [1:0]  cls_i;
  logic [31:0] pc_i, ps_i, ssp_i, tbr_i, rdata;
  logic        mem_req, mem_we, ssp_we, ps_we, pc_we, busy, done, recheck;
  logic [31:0] mem_addr, mem_wdata, ssp_o, ps_o, pc_o;

  int n_chk = 0;
  int n_fail = 0;
  string idle_tag = "R1";

  // reference model state
  int          m_phase = 0;
  logic [31:0] m_pc, m_ps, m_ssp, m_tbr;
  logic [4:0]  m_lvl;
  logic [7:0]  m_num;
  logic [1:0]  m_cls;

  always #2.5 clk = ~clk;

  irq_entry_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i),
    .irq_level_i(lvl_i), .irq_num_i(num_i), .insn_class_i(cls_i),
    .pc_i(pc_i), .ps_i(ps_i), .ssp_i(ssp_i), .tbr_i(tbr_i),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(rdata),
    .ssp_we_o(ssp_we), .ssp_o(ssp_o), .ps_we_o(ps_we), .ps_o(ps_o),
    .pc_we_o(pc_we), .pc_o(pc_o), .busy_o(busy), .done_o(done),
    .recheck_o(recheck)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_phase = 0;
    else if (m_phase == 0) begin
      if (start_i) begin
        m_pc = pc_i; m_ps = ps_i; m_ssp = ssp_i; m_tbr = tbr_i;
        m_lvl = lvl_i; m_num = num_i; m_cls = cls_i;
        m_phase = 1;
      end
    end else if (m_phase == 5) m_phase = 0;
    else m_phase = m_phase + 1;
  end

  function automatic logic [31:0] mem_fn(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  function automatic logic [31:0] ref_ra();
    case (m_cls)
      2'd2:    return m_pc + 32'd6;
      2'd1:    return m_pc + 32'd4;
      default: return m_pc + 32'd2;
    endcase
  endfunction

  function automatic logic [31:0] ref_vec();
    return m_tbr + 32'h3FC - 32'(m_num) * 32'd4;
  endfunction

  function automatic logic [31:0] ref_ps();
    logic [31:0] p;
    p = m_ps;
    p[20:16] = m_lvl;
    p[5] = 1'b0;
    return p;
  endfunction

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic check_cycle();
    string rq;
    case (m_phase)
      0: rq = idle_tag;
      1: rq = "R2";
      2: rq = "R3";
      3: rq = "R5";
      4: rq = "R6";
      default: rq = "R7";
    endcase
    chk(rq, "busy", 32'(busy), 32'(m_phase != 0));
    chk(rq, "mem_req", 32'(mem_req), 32'(m_phase >= 1 && m_phase <= 3));
    chk(rq, "mem_we", 32'(mem_we), 32'(m_phase == 1 || m_phase == 2));
    chk(rq, "ssp_we", 32'(ssp_we), 32'(m_phase == 1 || m_phase == 2));
    chk(rq, "ps_we", 32'(ps_we), 32'(m_phase == 3));
    chk(rq, "pc_we", 32'(pc_we), 32'(m_phase == 4));
    chk(rq, "done", 32'(done), 32'(m_phase == 5));
    chk(rq, "recheck", 32'(recheck), 32'(m_phase == 5));
    case (m_phase)
      1: begin
        chk("R2", "addr", mem_addr, m_ssp - 32'd4);
        chk("R2/R9", "wdata", mem_wdata, m_ps);
        chk("R2", "ssp", ssp_o, m_ssp - 32'd4);
      end
      2: begin
        chk("R3", "addr", mem_addr, m_ssp - 32'd8);
        chk("R4/R9", "ret_addr", mem_wdata, ref_ra());
        chk("R3", "ssp", ssp_o, m_ssp - 32'd8);
      end
      3: begin
        chk("R5", "ps", ps_o, ref_ps());
        chk("R6/R10", "vec_addr", mem_addr, ref_vec());
      end
      4: chk("R6", "pc", pc_o, mem_fn(ref_vec()));
      default: ;
    endcase
    // memory model: read data visible in the following cycle
    if (mem_req === 1'b1 && mem_we === 1'b0) rdata = mem_fn(mem_addr);
  endtask

  task automatic tick();
    @(negedge clk);
    check_cycle();
  endtask

  task automatic run_irq(input logic [31:0] pc, ps, ssp, tbr,
                         input logic [4:0] lvl, input logic [7:0] num,
                         input logic [1:0] cls, input bit poke);
    pc_i = pc; ps_i = ps; ssp_i = ssp; tbr_i = tbr;
    lvl_i = lvl; num_i = num; cls_i = cls; start_i = 1'b1;
    tick();
    start_i = 1'b0;
    if (poke) begin
      // R8, R9: new start and new inputs while busy must change nothing
      pc_i = ~pc; ps_i = ~ps; ssp_i = ssp ^ 32'h00F0_0F00;
      tbr_i = tbr + 32'h100; lvl_i = ~lvl; num_i = ~num; cls_i = ~cls;
      start_i = 1'b1;
      idle_tag = "R8";
    end
    for (int k = 0; k < 4; k++) tick();
    start_i = 1'b0;
    tick();
    tick();
    idle_tag = "R1";
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; lvl_i = '0; num_i = '0; cls_i = '0;
    pc_i = '0; ps_i = '0; ssp_i = '0; tbr_i = '0; rdata = '0;
    repeat (3) tick();  // R1 reset state
    rst_n = 1'b1;
    repeat (2) tick();
    run_irq(32'h0000_1000, 32'hFFFF_FFFF, 32'h0008_0000, 32'h000F_FC00, 5'h11, 8'h10, 2'd0, 1'b0); // R4 +2
    run_irq(32'h1234_5678, 32'hAAAA_AAAA, 32'h0000_2000, 32'h0001_0000, 5'h00, 8'h00, 2'd1, 1'b0); // R4 +4, R10
    run_irq(32'h8000_0010, 32'h5555_5555, 32'h0040_0010, 32'h0002_0000, 5'h1F, 8'hFF, 2'd2, 1'b1); // R4 +6, R10, R8, R9
    run_irq(32'hFFFF_FFFE, 32'h0000_0020, 32'h0000_0008, 32'h0000_0400, 5'h0A, 8'h7E, 2'd3, 1'b0); // R4 code 3
    run_irq(32'h0000_4000, 32'h0013_0020, 32'h0000_1000, 32'h0003_0000, 5'h15, 8'h01, 2'd2, 1'b1); // R8
    repeat (3) tick();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule